// File: doc/BRIEF.md
# Cross-Trigger Event Router

This block passes single-bit event triggers between the devices around it through a small number of shared, numbered channels. Each input trigger has a programmable mask that selects which channels it drives. Each output trigger has a mask that selects which channels drive it. A channel is active when any of these is true: an attached input trigger is high, software holds the channel set, or a one-cycle software pulse is in flight. Local channel activity goes out on a shared channel bus, and each channel has its own gate on that path. Activity that arrives from the bus is merged with local activity before the output triggers are formed.

Software programs the block through a flat register port. A write takes effect on the clock edge. A read is combinational. Two safety defaults apply out of reset: the global enable is off, and the output filter is on. The filter holds a chosen set of outputs low, such as a request that would halt a core. A reset-all command returns every register to its reset value.

Register word addresses: 0 control (bit0 global enable, bit1 filter enable), 1 gate, 2 channel set (reads back held channels), 3 channel clear, 4 channel pulse, 5 filtered-output mask, 6 reset-all, 7 channel-output status, 8 trigger-output status, 16+i input-i attach mask, 24+j output-j attach mask. Channel bit k of any mask is channel k.

Top module: `xtrig_router`

## Requirements
- R1: There are four channels. When input trigger i is high, every channel whose bit is set in input mask 16+i is locally active in the same cycle.
- R2: Output trigger j is high when any channel set in mask 24+j is active, either locally or on ch_in, subject to R7 and R9. Register 8 shows trig_out, with bit j for output j (output 6 high reads 0x40).
- R3: ch_out[k] is high only when channel k is locally active and gate bit k is set. The gate resets to 0xF, and a closed gate does not stop local outputs. Register 7 shows ch_out (channel 2 reads 0x4).
- R4: Writing mask m to address 2 holds channels m active. Only a write to address 3 (clearing the bits set in its data) or a reset-all releases them. Address 2 reads back the held set.
- R5: Writing mask m to address 4 makes channels m active for exactly the one cycle after the write edge.
- R6: After reset, all attach masks are zero. No input trigger, software hold or pulse has any effect until the block is programmed.
- R7: Filter enable (control bit1) resets to 1. While it is set, outputs whose bit is set in mask register 5 (reset value 0x01) stay low. When it is cleared, those outputs follow R2.
- R8: Writing data with bit0 = 1 to address 6 clears all attach masks, the held and pulsed channels, the enable, the gate and the filter settings back to their reset values.
- R9: Global enable (control bit0) resets to 0. While it is 0, trig_out and ch_out are all low.
- R10: Activity on ch_in never reaches ch_out, but it does drive attached outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| trig_in | input | 8 | Input triggers, synchronous levels |
| trig_out | output | 8 | Output triggers |
| ch_in | input | 4 | Channel activity from the shared bus |
| ch_out | output | 4 | Gated local channel activity to the bus |

## Verification
The bench uses the default parameters: eight inputs, eight outputs, four channels, and a filtered-output default of 0x01. At this size every mask is a single nibble, so random writes reach every attach register. Random stimulus also reaches every gate pattern and every filter and enable combination. A reference model in the bench then compares ch_out and trig_out with expectation on every cycle. Directed sequences cover the single-cycle pulse, the filtered output 0, a closed gate alongside an open local path, bus-only activity, and reset-all.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL      = 5'd0;
    localparam logic [ADDR_W-1:0] A_GATE      = 5'd1;
    localparam logic [ADDR_W-1:0] A_SET       = 5'd2;
    localparam logic [ADDR_W-1:0] A_CLR       = 5'd3;
    localparam logic [ADDR_W-1:0] A_PULSE     = 5'd4;
    localparam logic [ADDR_W-1:0] A_FMASK     = 5'd5;
    localparam logic [ADDR_W-1:0] A_RESET_ALL = 5'd6;
    localparam logic [ADDR_W-1:0] A_CH_STAT   = 5'd7;
    localparam logic [ADDR_W-1:0] A_TR_STAT   = 5'd8;

    localparam int IN_BASE  = 16;
    localparam int OUT_BASE = 24;
    localparam int MAX_PER_BANK = OUT_BASE - IN_BASE;
endpackage

// File: rtl/xtrig_in_map.sv
module xtrig_in_map #(
    parameter int NUM_IN = 8,
    parameter int NUM_CH = 4
) (
    input  logic [NUM_IN-1:0]             trig_in,
    input  logic [NUM_IN-1:0][NUM_CH-1:0] attach,
    output logic [NUM_CH-1:0]             ch_act
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_IN-1:0] column;
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            assign column[i] = attach[i][c];
        end
        assign ch_act[c] = |(trig_in & column);
    end
endmodule

// File: rtl/xtrig_out_map.sv
module xtrig_out_map #(
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4
) (
    input  logic                           enable,
    input  logic                           filt_en,
    input  logic [NUM_OUT-1:0]             filt_mask,
    input  logic [NUM_CH-1:0]              ch_all,
    input  logic [NUM_OUT-1:0][NUM_CH-1:0] attach,
    output logic [NUM_OUT-1:0]             trig_out
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign trig_out[o] = enable & (|(attach[o] & ch_all))
                             & ~(filt_en & filt_mask[o]);
    end
endmodule

// File: rtl/xtrig_router.sv
module xtrig_router
    import xtrig_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 32,
    parameter logic [NUM_OUT-1:0] FILT_DEFAULT = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_IN-1:0]   trig_in,
    output logic [NUM_OUT-1:0]  trig_out,
    input  logic [NUM_CH-1:0]   ch_in,
    output logic [NUM_CH-1:0]   ch_out
);
    localparam int WIDEST = (NUM_OUT > NUM_CH) ? NUM_OUT : NUM_CH;

    typedef struct packed {
        logic                           en;
        logic                           filt_en;
        logic [NUM_CH-1:0]              gate;
        logic [NUM_OUT-1:0]             filt_mask;
        logic [NUM_CH-1:0]              hold;
        logic [NUM_CH-1:0]              pulse;
        logic [NUM_IN-1:0][NUM_CH-1:0]  in_att;
        logic [NUM_OUT-1:0][NUM_CH-1:0] out_att;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s           = '0;
        s.filt_en   = 1'b1;
        s.gate      = '1;
        s.filt_mask = FILT_DEFAULT;
        return s;
    endfunction

    state_t st_d, st_q;

    logic [NUM_CH-1:0] in_ch, local_ch, ch_all;
    logic              glob_en, filt_en;
    logic [NUM_CH-1:0] gate_v, hold_v, pulse_v;
    logic [NUM_OUT-1:0] fmask_v;
    logic [NUM_IN-1:0][NUM_CH-1:0] in_att_v;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign glob_en  = st_q.en;
    assign filt_en  = st_q.filt_en;
    assign gate_v   = st_q.gate;
    assign hold_v   = st_q.hold;
    assign pulse_v  = st_q.pulse;
    assign fmask_v  = st_q.filt_mask;
    assign in_att_v = st_q.in_att;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        if (reg_wr) begin
            if (reg_addr == A_RESET_ALL && reg_wdata[0]) begin
                st_d = reset_state();
            end else begin
                case (reg_addr)
                    A_CTRL: begin
                        st_d.en      = reg_wdata[0];
                        st_d.filt_en = reg_wdata[1];
                    end
                    A_GATE:  st_d.gate      = reg_wdata[NUM_CH-1:0];
                    A_SET:   st_d.hold      = st_q.hold | reg_wdata[NUM_CH-1:0];
                    A_CLR:   st_d.hold      = st_q.hold & ~reg_wdata[NUM_CH-1:0];
                    A_PULSE: st_d.pulse     = reg_wdata[NUM_CH-1:0];
                    A_FMASK: st_d.filt_mask = reg_wdata[NUM_OUT-1:0];
                    default: ;
                endcase
                for (int i = 0; i < NUM_IN; i++) begin
                    if (reg_addr == ADDR_W'(IN_BASE + i))
                        st_d.in_att[i] = reg_wdata[NUM_CH-1:0];
                end
                for (int o = 0; o < NUM_OUT; o++) begin
                    if (reg_addr == ADDR_W'(OUT_BASE + o))
                        st_d.out_att[o] = reg_wdata[NUM_CH-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    xtrig_in_map #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH)) u_in_map (
        .trig_in (trig_in),
        .attach  (st_q.in_att),
        .ch_act  (in_ch)
    );

    assign local_ch = in_ch | st_q.hold | st_q.pulse;
    assign ch_all   = local_ch | ch_in;
    assign ch_out   = {NUM_CH{st_q.en}} & st_q.gate & local_ch;

    xtrig_out_map #(.NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_out_map (
        .enable    (st_q.en),
        .filt_en   (st_q.filt_en),
        .filt_mask (st_q.filt_mask),
        .ch_all    (ch_all),
        .attach    (st_q.out_att),
        .trig_out  (trig_out)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:    reg_rdata[1:0]         = {st_q.filt_en, st_q.en};
            A_GATE:    reg_rdata[NUM_CH-1:0]  = st_q.gate;
            A_SET:     reg_rdata[NUM_CH-1:0]  = st_q.hold;
            A_FMASK:   reg_rdata[NUM_OUT-1:0] = st_q.filt_mask;
            A_CH_STAT: reg_rdata[NUM_CH-1:0]  = ch_out;
            A_TR_STAT: reg_rdata[NUM_OUT-1:0] = trig_out;
            default: ;
        endcase
        for (int i = 0; i < NUM_IN; i++) begin
            if (reg_addr == ADDR_W'(IN_BASE + i))
                reg_rdata[NUM_CH-1:0] = st_q.in_att[i];
        end
        for (int o = 0; o < NUM_OUT; o++) begin
            if (reg_addr == ADDR_W'(OUT_BASE + o))
                reg_rdata[NUM_CH-1:0] = st_q.out_att[o];
        end
    end

    initial begin
        if (NUM_IN > MAX_PER_BANK || NUM_OUT > MAX_PER_BANK || WIDEST > DATA_W)
            $error("xtrig_router: parameters exceed the register map");
    end
endmodule

// File: rtl/xtrig_router_chk.sv
module xtrig_router_chk
    import xtrig_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic                          wbit0,
    input logic [NUM_CH-1:0]             ch_out,
    input logic [NUM_OUT-1:0]            trig_out,
    input logic                          glob_en,
    input logic                          filt_en,
    input logic [NUM_CH-1:0]             gate_v,
    input logic [NUM_OUT-1:0]            fmask_v,
    input logic [NUM_CH-1:0]             hold_v,
    input logic [NUM_CH-1:0]             pulse_v,
    input logic [NUM_IN-1:0][NUM_CH-1:0] in_att_v
);
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_out & ~gate_v) == '0);  // R3

    AST_NO_EN_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (trig_out == '0 && ch_out == '0));  // R9

    AST_FILTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en |-> (trig_out & fmask_v) == '0);  // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_PULSE) |=> pulse_v == '0);  // R5

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == A_CLR || reg_addr == A_RESET_ALL))
        |=> (hold_v & $past(hold_v)) == $past(hold_v));  // R4

    AST_RESET_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_RESET_ALL && wbit0)
        |=> (hold_v == '0 && in_att_v == '0 && !glob_en && filt_en));  // R8
endmodule

bind xtrig_router xtrig_router_chk #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wbit0(reg_wdata[0]), .ch_out(ch_out), .trig_out(trig_out),
    .glob_en(glob_en), .filt_en(filt_en), .gate_v(gate_v), .fmask_v(fmask_v),
    .hold_v(hold_v), .pulse_v(pulse_v), .in_att_v(in_att_v)
);

// File: tb/sim_xtrig_router.sv
module sim_xtrig_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  trig_in = '0;
    logic [7:0]  trig_out;
    logic [3:0]  ch_in = '0;
    logic [3:0]  ch_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference state
    logic       m_en, m_filt;
    logic [3:0] m_gate, m_hold, m_pulse;
    logic [7:0] m_mask;
    logic [3:0] m_in [8];
    logic [3:0] m_out [8];

    always #10 clk = ~clk;

    xtrig_router u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .trig_out(trig_out), .ch_in(ch_in), .ch_out(ch_out)
    );

    task automatic model_reset();
        m_en = 1'b0; m_filt = 1'b1; m_gate = 4'hF; m_hold = '0;
        m_pulse = '0; m_mask = 8'h01;
        for (int i = 0; i < 8; i++) begin m_in[i] = '0; m_out[i] = '0; end
    endtask

    function automatic logic [3:0] f_local(input logic [7:0] ti);
        logic [3:0] c = m_hold | m_pulse;
        for (int i = 0; i < 8; i++) if (ti[i]) c |= m_in[i];
        return c;
    endfunction

    function automatic logic [3:0] f_ch_out(input logic [7:0] ti);
        return m_en ? (f_local(ti) & m_gate) : 4'h0;
    endfunction

    function automatic logic [7:0] f_trig(input logic [7:0] ti, input logic [3:0] ci);
        logic [7:0] t = '0;
        logic [3:0] all = f_local(ti) | ci;
        for (int o = 0; o < 8; o++)
            t[o] = m_en && (|(m_out[o] & all)) && !(m_filt && m_mask[o]);
        return t;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts and ends just after a falling edge
    task automatic step(input logic wr, input logic [4:0] a, input logic [31:0] d,
                        input logic [7:0] ti, input logic [3:0] ci);
        reg_wr = wr; reg_addr = a; reg_wdata = d; trig_in = ti; ch_in = ci;
        #2;
        chk({28'd0, ch_out}, {28'd0, f_ch_out(ti)}, "R1 R3 ch_out");
        chk({24'd0, trig_out}, {24'd0, f_trig(ti, ci)}, "R2 R7 R9 trig_out");
        @(posedge clk);
        #1;
        m_pulse = '0;
        if (wr) begin
            if (a == 5'd6 && d[0]) model_reset();
            else begin
                case (a)
                    5'd0: begin m_en = d[0]; m_filt = d[1]; end
                    5'd1: m_gate = d[3:0];
                    5'd2: m_hold = m_hold | d[3:0];
                    5'd3: m_hold = m_hold & ~d[3:0];
                    5'd4: m_pulse = d[3:0];
                    5'd5: m_mask = d[7:0];
                    default: ;
                endcase
                if (a >= 5'd16 && a < 5'd24) m_in[a - 5'd16] = d[3:0];
                if (a >= 5'd24) m_out[a - 5'd24] = d[3:0];
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        reg_wr = 1'b0; reg_addr = a;
        #2;
        chk(reg_rdata, exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset values
        rd(5'd0, 32'h2, "R9 R7 control reset");
        rd(5'd1, 32'hF, "R3 gate reset");
        rd(5'd5, 32'h01, "R7 filter mask reset");
        rd(5'd17, 32'h0, "R6 attach reset");
        step(1'b0, 5'd0, 0, 8'hFF, 4'hF);   // R6: nothing attached, all low
        step(1'b1, 5'd4, 32'hF, 8'hFF, 4'h0);
        step(1'b0, 5'd0, 0, 8'hFF, 4'h0);   // R6: pulse with no attachment
        chk({24'd0, trig_out}, 32'h0, "R6 no effect before programming");

        // input 1 -> ch2 -> output 6
        step(1'b1, 5'd17, 32'h4, 8'h00, 4'h0);
        step(1'b1, 5'd30, 32'h4, 8'h00, 4'h0);
        step(1'b1, 5'd0,  32'h3, 8'h00, 4'h0);
        step(1'b1, 5'd2,  32'h4, 8'h00, 4'h0);
        rd(5'd7, 32'h4, "R3 channel status ch2");
        rd(5'd8, 32'h40, "R2 trigger status out6");
        rd(5'd2, 32'h4, "R4 held set readback");
        step(1'b0, 5'd0, 0, 8'h00, 4'h0);
        rd(5'd8, 32'h40, "R4 hold persists");
        step(1'b1, 5'd3, 32'h4, 8'h00, 4'h0);
        rd(5'd8, 32'h0, "R4 cleared");
        step(1'b0, 5'd0, 0, 8'h02, 4'h0);
        rd(5'd7, 32'h4, "R1 input drives channel");
        step(1'b0, 5'd0, 0, 8'h00, 4'h0);

        // pulse
        step(1'b1, 5'd4, 32'h4, 8'h00, 4'h0);
        rd(5'd8, 32'h40, "R5 pulse cycle");
        step(1'b0, 5'd0, 0, 8'h00, 4'h0);
        rd(5'd8, 32'h0, "R5 pulse over");

        // filter on output 0
        step(1'b1, 5'd24, 32'h4, 8'h00, 4'h0);
        step(1'b1, 5'd2,  32'h4, 8'h00, 4'h0);
        rd(5'd8, 32'h40, "R7 output 0 filtered");
        step(1'b1, 5'd0,  32'h1, 8'h00, 4'h0);
        rd(5'd8, 32'h41, "R7 filter off");

        // gate closed on ch2
        step(1'b1, 5'd1, 32'hB, 8'h00, 4'h0);
        rd(5'd7, 32'h0, "R3 gate closed");
        rd(5'd8, 32'h41, "R3 local outputs unaffected");
        step(1'b1, 5'd1, 32'hF, 8'h00, 4'h0);
        step(1'b1, 5'd3, 32'h4, 8'h00, 4'h0);

        // bus input only
        step(1'b0, 5'd0, 0, 8'h00, 4'h4);
        rd(5'd8, 32'h41, "R10 bus drives outputs");
        rd(5'd7, 32'h0, "R10 bus not echoed");
        step(1'b0, 5'd0, 0, 8'h00, 4'h0);

        // global enable off
        step(1'b1, 5'd0, 32'h0, 8'h00, 4'h0);
        step(1'b1, 5'd2, 32'h4, 8'h02, 4'hF);
        rd(5'd8, 32'h0, "R9 disabled outputs");
        rd(5'd7, 32'h0, "R9 disabled channels");

        // reset-all
        step(1'b1, 5'd0, 32'h1, 8'h00, 4'h0);
        step(1'b1, 5'd6, 32'h1, 8'h00, 4'h0);
        rd(5'd0, 32'h2, "R8 control restored");
        rd(5'd17, 32'h0, "R8 input attach cleared");
        rd(5'd30, 32'h0, "R8 output attach cleared");
        rd(5'd2, 32'h0, "R8 hold cleared");
        rd(5'd1, 32'hF, "R8 gate restored");

        // constrained random
        void'($urandom(32'd2024));
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom % 25;
            logic [4:0] a = (r < 9) ? 5'(r) : 5'(16 + r - 9);
            logic wr = ($urandom % 2) == 0;
            if (a == 5'd6 && ($urandom % 4) != 0) wr = 1'b0;
            step(wr, a, $urandom, 8'($urandom), 4'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule